// File: doc/BRIEF.md
# Posted/Pending Interrupt Controller

This block collects interrupt events from a parameterised number of hardware sources and holds each one in a posted bit until it is serviced or cleared. A per-source mask turns posted bits into pending requests. The block raises a single request to the CPU when at least one request is pending and the CPU's global interrupt enable is set. It also presents the index of the lowest-numbered pending source as the vector. When the CPU signals that it has taken the interrupt, only the serviced source's posted bit is cleared.

Firmware sees every posted bit through the status read port, whatever the masks hold. One write port serves two purposes, selected by a software-interrupt enable input. With the enable low, a write clears each bit that is written as 0. With the enable high, a write posts each bit that is written as 1. This lets firmware raise any interrupt itself.

Top module: `intr_ctrl`

## Requirements
- R1: While reset is asserted and after it is released, all posted bits and all mask bits are 0, and irq_o is low.
- R2: A high src_evt_i[i] at a clock edge sets posted bit i, and posted_o[i] shows it from that edge on. The bit stays set until a clear or an acknowledge removes it.
- R3: With swint_en_i low, a clr_wr_i write clears every posted bit whose clr_wdata_i bit is 0. Bits written as 1 keep their value.
- R4: With swint_en_i high, a clr_wr_i write sets every posted bit whose clr_wdata_i bit is 1. Bits written as 0 keep their value.
- R5: posted_o reports every posted bit, whether that source is masked or not.
- R6: A mask_wr_i write loads mask_wdata_i into the mask at the clock edge. Bit i = 1 enables source i. A posted bit whose mask bit is 0 never causes irq_o.
- R7: irq_o is high only when gie_i is high and at least one bit is set in both the posted bits and the mask. With gie_i low, irq_o is low.
- R8: While irq_o is high, vec_o gives the lowest index i for which both the posted bit and the mask bit are set. Index 0 has the highest priority.
- R9: ack_i high while irq_o is high clears, at that clock edge, only the posted bit at index vec_o.
- R10: If a source event arrives in the same cycle as a clear write or an acknowledge for that bit, the event wins and the bit stays posted.
- R11: ack_i while irq_o is low changes no posted bit.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| src_evt_i | input | N_SRC | Interrupt events, one per source |
| gie_i | input | 1 | Global interrupt enable from the CPU flags |
| mask_wr_i | input | 1 | Mask write strobe |
| mask_wdata_i | input | N_SRC | New mask value, 1 = enabled |
| clr_wr_i | input | 1 | Write strobe for the clear/post port |
| clr_wdata_i | input | N_SRC | Write data for the clear/post port |
| swint_en_i | input | 1 | 0: writes clear bits written as 0; 1: writes post bits written as 1 |
| ack_i | input | 1 | CPU has taken the interrupt at vec_o |
| posted_o | output | N_SRC | All posted bits |
| irq_o | output | 1 | Interrupt request to the CPU |
| vec_o | output | VEC_W | Index of the highest-priority pending source |

## Verification
The assertions take all inputs as synchronous to clk_i and stable around the rising edge. They also assume ack_i has meaning only while irq_o is high. An acknowledge under a low irq_o is legal input, and the block must ignore it. The bench changes every input just after the falling edge and checks at the next falling edge, which keeps the stimulus inside these assumptions. The random phase deliberately issues acknowledges while the request is low, and combines events with clears and acknowledges on the same bit in the same cycle.

// File: rtl/intr_ctrl_pkg.sv
package intr_ctrl_pkg;
  localparam int unsigned DEF_N_SRC = 16;

  typedef enum logic {
    WR_CLEAR = 1'b0,
    WR_POST  = 1'b1
  } clr_mode_e;
endpackage

// File: rtl/intr_mask_reg.sv
module intr_mask_reg #(
  parameter int unsigned N_SRC = 16
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             wr_i,
  input  logic [N_SRC-1:0] wdata_i,
  output logic [N_SRC-1:0] mask_o
);
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)   mask_o <= '0;
    else if (wr_i) mask_o <= wdata_i;
  end

  assert_mask_load_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    wr_i |=> mask_o == $past(wdata_i));
endmodule

// File: rtl/intr_post_bank.sv
module intr_post_bank
  import intr_ctrl_pkg::*;
#(
  parameter int unsigned N_SRC = 16
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic [N_SRC-1:0] evt_i,
  input  logic             wr_i,
  input  logic [N_SRC-1:0] wdata_i,
  input  clr_mode_e        mode_i,
  input  logic [N_SRC-1:0] ack_clr_i,
  output logic [N_SRC-1:0] posted_o
);
  for (genvar i = 0; i < N_SRC; i++) begin : g_bit
    logic set_b, clr_b;
    always_comb begin
      set_b = evt_i[i] | (wr_i & (mode_i == WR_POST) & wdata_i[i]);
      clr_b = ack_clr_i[i] | (wr_i & (mode_i == WR_CLEAR) & ~wdata_i[i]);
    end
    // set has precedence: a fresh event is never lost
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni)    posted_o[i] <= 1'b0;
      else if (set_b) posted_o[i] <= 1'b1;
      else if (clr_b) posted_o[i] <= 1'b0;
    end

    assert_evt_posts_R2_R10: assert property (@(posedge clk_i) disable iff (!rst_ni)
      evt_i[i] |=> posted_o[i]);
    assert_clr_zero_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (wr_i && mode_i == WR_CLEAR && !wdata_i[i] && !evt_i[i]) |=> !posted_o[i]);
    assert_sw_post_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (wr_i && mode_i == WR_POST && wdata_i[i]) |=> posted_o[i]);
    assert_idle_hold_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (!evt_i[i] && !wr_i && !ack_clr_i[i]) |=> $stable(posted_o[i]));
  end
endmodule

// File: rtl/intr_prio_enc.sv
module intr_prio_enc #(
  parameter int unsigned N_SRC = 16,
  localparam int unsigned VEC_W = (N_SRC > 1) ? $clog2(N_SRC) : 1
) (
  input  logic [N_SRC-1:0] req_i,
  output logic             valid_o,
  output logic [VEC_W-1:0] idx_o
);
  always_comb begin
    valid_o = |req_i;
    idx_o   = '0;
    for (int i = N_SRC - 1; i >= 0; i--) begin
      if (req_i[i]) idx_o = VEC_W'(i);
    end
  end
endmodule

// File: rtl/intr_ctrl.sv
module intr_ctrl
  import intr_ctrl_pkg::*;
#(
  parameter int unsigned N_SRC = DEF_N_SRC,
  localparam int unsigned VEC_W = (N_SRC > 1) ? $clog2(N_SRC) : 1
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic [N_SRC-1:0] src_evt_i,
  input  logic             gie_i,
  input  logic             mask_wr_i,
  input  logic [N_SRC-1:0] mask_wdata_i,
  input  logic             clr_wr_i,
  input  logic [N_SRC-1:0] clr_wdata_i,
  input  logic             swint_en_i,
  input  logic             ack_i,
  output logic [N_SRC-1:0] posted_o,
  output logic             irq_o,
  output logic [VEC_W-1:0] vec_o
);
  logic [N_SRC-1:0] mask_w, posted_w, pend_w, ack_clr_w;
  logic             any_pend_w;
  clr_mode_e        mode_w;

  assign mode_w = swint_en_i ? WR_POST : WR_CLEAR;

  intr_mask_reg #(.N_SRC(N_SRC)) u_mask (
    .clk_i(clk_i), .rst_ni(rst_ni), .wr_i(mask_wr_i),
    .wdata_i(mask_wdata_i), .mask_o(mask_w)
  );

  intr_post_bank #(.N_SRC(N_SRC)) u_bank (
    .clk_i(clk_i), .rst_ni(rst_ni), .evt_i(src_evt_i),
    .wr_i(clr_wr_i), .wdata_i(clr_wdata_i), .mode_i(mode_w),
    .ack_clr_i(ack_clr_w), .posted_o(posted_w)
  );

  assign pend_w = posted_w & mask_w;

  intr_prio_enc #(.N_SRC(N_SRC)) u_enc (
    .req_i(pend_w), .valid_o(any_pend_w), .idx_o(vec_o)
  );

  assign irq_o     = gie_i & any_pend_w;
  assign ack_clr_w = (ack_i && irq_o) ? (N_SRC'(1) << vec_o) : '0;
  assign posted_o  = posted_w;

  assert_gie_gate_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !gie_i |-> !irq_o);
  assert_vec_pending_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    irq_o |-> (posted_w[vec_o] && mask_w[vec_o]));
  assert_vec_lowest_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    irq_o |-> ((posted_w & mask_w & ((N_SRC'(1) << vec_o) - N_SRC'(1))) == '0));
  assert_ack_clears_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (ack_i && irq_o && !src_evt_i[vec_o] && !(clr_wr_i && swint_en_i && clr_wdata_i[vec_o]))
    |=> !posted_w[$past(vec_o)]);
  assert_ack_onehot_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $onehot0(ack_clr_w));
  assert_ack_idle_R11: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (ack_i && !irq_o && !clr_wr_i && src_evt_i == '0) |=> $stable(posted_w));
endmodule

// File: tb/intr_ctrl_tb_top.sv
`timescale 1ns/1ps
module intr_ctrl_tb_top;
  localparam int N = 16;
  localparam int VW = 4;

  logic clk = 1'b0, rst_n = 1'b0;
  logic [N-1:0] evt = '0, mwd = '0, cwd = '0;
  logic gie = 1'b0, mwr = 1'b0, cwr = 1'b0, swen = 1'b0, ack = 1'b0;
  logic [N-1:0] posted;
  logic irq;
  logic [VW-1:0] vec;

  int checks = 0, errors = 0;
  string tag = "R1";
  bit done = 1'b0;

  always #4 clk = ~clk;

  intr_ctrl #(.N_SRC(N)) dut_i (
    .clk_i(clk), .rst_ni(rst_n), .src_evt_i(evt), .gie_i(gie),
    .mask_wr_i(mwr), .mask_wdata_i(mwd), .clr_wr_i(cwr), .clr_wdata_i(cwd),
    .swint_en_i(swen), .ack_i(ack), .posted_o(posted), .irq_o(irq), .vec_o(vec)
  );

  // behavioural reference
  logic [N-1:0] m_post = '0, m_mask = '0;

  function automatic int lowest(input logic [N-1:0] v);
    for (int i = 0; i < N; i++) if (v[i]) return i;
    return -1;
  endfunction

  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      m_post <= '0; m_mask <= '0;
    end else begin
      logic [N-1:0] nxt;
      int lo;
      nxt = m_post;
      lo = lowest(m_post & m_mask);
      if (ack && gie && lo >= 0) nxt[lo] = 1'b0;
      if (cwr && !swen) nxt = nxt & cwd;
      if (cwr && swen) nxt = nxt | cwd;
      nxt = nxt | evt;
      m_post <= nxt;
      if (mwr) m_mask <= mwd;
    end
  end

  task automatic compare();
    int lo;
    logic e_irq;
    lo = lowest(m_post & m_mask);
    e_irq = gie && (lo >= 0);
    checks++;
    if (posted !== m_post) begin
      errors++; $display("FAIL %s posted act=%h exp=%h", tag, posted, m_post);
    end
    checks++;
    if (irq !== e_irq) begin
      errors++; $display("FAIL %s irq act=%b exp=%b", tag, irq, e_irq);
    end
    if (e_irq) begin
      checks++;
      if (vec !== VW'(lo)) begin
        errors++; $display("FAIL %s vec act=%0d exp=%0d", tag, vec, lo);
      end
    end
  endtask

  task automatic idle();
    evt = '0; mwr = 1'b0; cwr = 1'b0; ack = 1'b0;
  endtask

  task automatic step();
    @(negedge clk);
    compare();
    idle();
  endtask

  initial begin
    #400000;
    errors++;
    $display("FAIL watchdog act=timeout exp=done");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    tag = "R1";
    repeat (3) @(negedge clk);
    compare();
    rst_n = 1'b1;
    step(); step();
    // R2 event posting while masked; R5 visible anyway
    tag = "R2"; evt = 16'h0208; step(); step(); step();
    tag = "R5"; gie = 1'b1; step();
    // R6 mask enables only source 9
    tag = "R6"; mwr = 1'b1; mwd = 16'h0200; step(); step();
    // R8 lowest wins
    tag = "R8"; mwr = 1'b1; mwd = 16'hFFFF; step(); step();
    // R7 global gate
    tag = "R7"; gie = 1'b0; step(); step();
    // R11 ack ignored while irq low
    tag = "R11"; ack = 1'b1; step(); step();
    // R9 ack clears only serviced bit (3), then 9 becomes vector
    tag = "R9"; gie = 1'b1; ack = 1'b1; step(); step();
    // R3 clear-by-zero leaves bits written 1
    tag = "R3"; evt = 16'h0030; step();
    cwr = 1'b1; swen = 1'b0; cwd = ~16'h0200; step(); step();
    cwr = 1'b1; cwd = 16'h0000; step(); step();
    // R4 software post, bits written 0 untouched
    tag = "R4"; evt = 16'h4000; step();
    cwr = 1'b1; swen = 1'b1; cwd = 16'h0081; step(); step();
    // R10 event beats clear write and ack in the same cycle
    tag = "R10"; cwr = 1'b1; swen = 1'b0; cwd = 16'h0000; evt = 16'h0001; step(); step();
    ack = 1'b1; evt = 16'h0001; step(); step();
    // random mix
    tag = "R8";
    for (int k = 0; k < 3000; k++) begin
      evt  = ($urandom_range(0, 3) == 0) ? N'($urandom) & N'($urandom) : '0;
      gie  = ($urandom_range(0, 4) != 0);
      mwr  = ($urandom_range(0, 15) == 0); mwd = N'($urandom);
      cwr  = ($urandom_range(0, 7) == 0);  cwd = N'($urandom) | N'($urandom);
      swen = $urandom_range(0, 1);
      ack  = ($urandom_range(0, 2) == 0);
      @(negedge clk);
      compare();
    end
    idle();
    step();
    done = 1'b1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule